// File: doc/BRIEF.md
# Exponential-Minus-One Operand Front End

This block sits in front of the series datapath that evaluates 2^x - 1 for an 80-bit extended-precision operand. Each accepted operand is sorted into one class, such as zero, normal, denormal, infinity, quiet or signalling NaN, or one of the malformed encodings. The block then either finishes the instruction itself, returning the final value and the final status word, or hands the operand on to the series datapath with a request strobe. The request strobe says whether the operand was a denormal and whether it is small enough for the cheap linear approximation.

The block has one register stage. An operand presented with `in_valid` in one cycle produces exactly one of two outputs one cycle later: a finished result (`out_valid`) or a compute request (`cmp_req`). For a compute request, `out_result` carries the operand unchanged and `out_status` carries the status word the datapath should start from.

Operand layout: bit 79 is the sign, bits 78:64 are the biased exponent (bias 16383), and bits 63:0 are the explicit mantissa. Control-word mask bits: invalid mask IM = bit 0, denormal mask DM = bit 1, precision mask PM = bit 5. Status-word bits: IE = 0, DE = 1, PE = 5, ES = 7, C0 = 8, C2 = 10, TOP = 13:11, C3 = 14, B = 15.

Top module: `f2x_front`

## Requirements
- R1: For every produced output, the status word copies C0 (bit 8), C2 (bit 10) and C3 (bit 14) from `in_status`, has TOP (bits 13:11) equal to 7, and has all other bits cleared apart from the flags named in R2 to R8.
- R2: A normal operand (exponent neither 0 nor 0x7FFF, mantissa bit 63 set) with exponent below 16383 raises `cmp_req`, not `out_valid`. `out_result` carries the operand and no flag is added.
- R3: +1.0 (exponent 16383, mantissa 0x8000000000000000) returns +1.0. -1.0 returns -0.5, with exponent 16382 and mantissa 0x8000000000000000.
- R4: Every other normal operand with exponent at least 16383 is returned unchanged. For these operands and for ±1.0, PE is set, and ES and B are also set when PM is clear.
- R5: Zeros, quiet NaNs (exponent 0x7FFF, mantissa bits 63 and 62 set) and the indefinite value are returned unchanged, with no flag added.
- R6: +Inf (exponent 0x7FFF, mantissa 0x8000000000000000) returns +Inf. -Inf returns -1.0.
- R7: A denormal (exponent 0, bit 63 clear, mantissa nonzero) or pseudo-denormal (exponent 0, bit 63 set) sets DE. With DM set it raises `cmp_req` with `cmp_denorm` high. With DM clear it returns the operand unchanged with ES and B set.
- R8: An unnormal (exponent neither 0 nor 0x7FFF, bit 63 clear) or a pseudo-NaN (exponent 0x7FFF, bit 63 clear) returns the negative indefinite value (sign 1, exponent 0x7FFF, mantissa 0xC000000000000000) when IM is set. A signalling NaN (exponent 0x7FFF, bit 63 set, bit 62 clear, lower bits nonzero) returns with mantissa bit 62 forced to 1 when IM is set. With IM clear, each of these returns the operand unchanged. All of them set IE, and also ES and B when IM is clear.
- R9: Outputs appear exactly one cycle after `in_valid`. `out_valid` and `cmp_req` are never high together, and both are low in a cycle that follows no input.
- R10: `cmp_short` is high with `cmp_req` when the operand's exponent field is at most 16383 - 69 = 16314, which includes every denormal input, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_operand | input | 80 | Extended-precision operand |
| in_ctrl | input | 16 | Control word (IM, DM, PM masks) |
| in_status | input | 16 | Current status word |
| out_valid | output | 1 | Finished result is present |
| out_result | output | 80 | Result, or the forwarded operand on a request |
| out_status | output | 16 | Final or starting status word |
| cmp_req | output | 1 | Series datapath must compute the result |
| cmp_denorm | output | 1 | Requested operand was a denormal or pseudo-denormal |
| cmp_short | output | 1 | Requested operand qualifies for the linear short path |

## Verification
On every cycle, the assertions check the one-cycle timing and that the two output strobes are mutually exclusive. They also check that TOP reads 7 on every output, that ES and B always move together, that a request never carries IE or PE, and that a denormal request always carries DE. Only the bench scenarios can show the values themselves: the exact ±1.0 and -Inf results, the indefinite substitution, the quieting of a signalling NaN, and the boundary of the short-path exponent.

// File: rtl/f2x_pkg.sv
package f2x_pkg;
  localparam int EXP_W   = 15;
  localparam int MAN_W   = 64;
  localparam int FP_W    = 1 + EXP_W + MAN_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_TOP = (1 << EXP_W) - 1;
  localparam int SW_W    = 16;

  // control-word mask positions
  localparam int CW_IM = 0;
  localparam int CW_DM = 1;
  localparam int CW_PM = 5;

  // status-word positions
  localparam int SW_IE  = 0;
  localparam int SW_DE  = 1;
  localparam int SW_PE  = 5;
  localparam int SW_ES  = 7;
  localparam int SW_C0  = 8;
  localparam int SW_C2  = 10;
  localparam int SW_TLO = 11;
  localparam int SW_C3  = 14;
  localparam int SW_B   = 15;

  typedef enum logic [3:0] {
    CLS_ZERO,
    CLS_DENORM,
    CLS_PDENORM,
    CLS_NORMAL,
    CLS_UNNORMAL,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN,
    CLS_PNAN
  } opclass_e;

  function automatic logic fp_sign(input logic [FP_W-1:0] v);
    return v[FP_W-1];
  endfunction

  function automatic logic [EXP_W-1:0] fp_exp(input logic [FP_W-1:0] v);
    return v[MAN_W +: EXP_W];
  endfunction

  function automatic logic [MAN_W-1:0] fp_man(input logic [FP_W-1:0] v);
    return v[MAN_W-1:0];
  endfunction

  function automatic logic [FP_W-1:0] fp_pack(input logic s, input logic [EXP_W-1:0] e,
                                              input logic [MAN_W-1:0] m);
    return {s, e, m};
  endfunction

  // integer bit alone: mantissa of an exact power of two
  function automatic logic [MAN_W-1:0] man_unit();
    logic [MAN_W-1:0] m;
    m = '0;
    m[MAN_W-1] = 1'b1;
    return m;
  endfunction

  // starting status word: condition bits kept, TOP forced to 7
  function automatic logic [SW_W-1:0] sw_seed(input logic [SW_W-1:0] sw);
    logic [SW_W-1:0] r;
    r = '0;
    r[SW_C0] = sw[SW_C0];
    r[SW_C2] = sw[SW_C2];
    r[SW_C3] = sw[SW_C3];
    r[SW_TLO +: 3] = 3'b111;
    return r;
  endfunction

  function automatic logic [SW_W-1:0] sw_raise(input logic [SW_W-1:0] sw, input int pos,
                                               input logic unmasked);
    logic [SW_W-1:0] r;
    r = sw;
    r[pos] = 1'b1;
    if (unmasked) begin
      r[SW_ES] = 1'b1;
      r[SW_B]  = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/f2x_classify.sv
module f2x_classify
  import f2x_pkg::*;
#(
  parameter int SHORT_GAP = 69
) (
  input  logic [FP_W-1:0] operand,
  output opclass_e        cls,
  output logic            exp_short
);
  localparam int SHORT_LIMIT = BIAS - SHORT_GAP;

  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic             exp_zero, exp_full, int_bit, quiet_bit, frac_zero;

  assign ex        = fp_exp(operand);
  assign mn        = fp_man(operand);
  assign exp_zero  = (ex == '0);
  assign exp_full  = (ex == EXP_W'(EXP_TOP));
  assign int_bit   = mn[MAN_W-1];
  assign quiet_bit = mn[MAN_W-2];
  assign frac_zero = (mn[MAN_W-2:0] == '0);
  assign exp_short = (ex <= EXP_W'(SHORT_LIMIT));

  always_comb begin
    if (exp_zero) begin
      if (mn == '0)   cls = CLS_ZERO;
      else if (int_bit) cls = CLS_PDENORM;
      else              cls = CLS_DENORM;
    end else if (exp_full) begin
      if (!int_bit)       cls = CLS_PNAN;
      else if (frac_zero) cls = CLS_INF;
      else if (quiet_bit) cls = CLS_QNAN;
      else                cls = CLS_SNAN;
    end else begin
      cls = int_bit ? CLS_NORMAL : CLS_UNNORMAL;
    end
  end
endmodule

// File: rtl/f2x_resolve.sv
module f2x_resolve
  import f2x_pkg::*;
(
  input  logic [FP_W-1:0] operand,
  input  opclass_e        cls,
  input  logic [SW_W-1:0] ctrl,
  input  logic [SW_W-1:0] stat,
  output logic [FP_W-1:0] res,
  output logic [SW_W-1:0] st,
  output logic            want_compute,
  output logic            was_denorm
);
  logic             sg;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  logic [FP_W-1:0]  indefinite;
  logic [FP_W-1:0]  minus_one;
  logic             exact_one;

  assign sg         = fp_sign(operand);
  assign ex         = fp_exp(operand);
  assign mn         = fp_man(operand);
  assign indefinite = fp_pack(1'b1, EXP_W'(EXP_TOP), {2'b11, {(MAN_W-2){1'b0}}});
  assign minus_one  = fp_pack(1'b1, EXP_W'(BIAS), man_unit());
  assign exact_one  = (ex == EXP_W'(BIAS)) && (mn == man_unit());

  always_comb begin
    res          = operand;
    st           = sw_seed(stat);
    want_compute = 1'b0;
    was_denorm   = 1'b0;
    unique case (cls)
      CLS_NORMAL: begin
        if (ex < EXP_W'(BIAS)) begin
          want_compute = 1'b1;
        end else begin
          if (exact_one) res = fp_pack(sg, EXP_W'(BIAS) - EXP_W'(sg), man_unit());
          st = sw_raise(st, SW_PE, !ctrl[CW_PM]);
        end
      end
      CLS_INF: begin
        if (sg) res = minus_one;
      end
      CLS_DENORM, CLS_PDENORM: begin
        st[SW_DE] = 1'b1;
        if (ctrl[CW_DM]) begin
          want_compute = 1'b1;
          was_denorm   = 1'b1;
        end else begin
          st = sw_raise(st, SW_DE, 1'b1);
        end
      end
      CLS_UNNORMAL, CLS_PNAN: begin
        if (ctrl[CW_IM]) res = indefinite;
        st = sw_raise(st, SW_IE, !ctrl[CW_IM]);
      end
      CLS_SNAN: begin
        if (ctrl[CW_IM]) res[MAN_W-2] = 1'b1;
        st = sw_raise(st, SW_IE, !ctrl[CW_IM]);
      end
      default: begin
        // zero and quiet NaN (indefinite included) pass through untouched
      end
    endcase
  end
endmodule

// File: rtl/f2x_front.sv
module f2x_front
  import f2x_pkg::*;
#(
  parameter int SHORT_GAP = 69
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FP_W-1:0]   in_operand,
  input  logic [SW_W-1:0]   in_ctrl,
  input  logic [SW_W-1:0]   in_status,
  output logic              out_valid,
  output logic [FP_W-1:0]   out_result,
  output logic [SW_W-1:0]   out_status,
  output logic              cmp_req,
  output logic              cmp_denorm,
  output logic              cmp_short
);
  opclass_e        cls;
  logic            exp_short;
  logic [FP_W-1:0] res_d;
  logic [SW_W-1:0] st_d;
  logic            want_compute, was_denorm;
  logic            dir_fire, cmp_fire, any_out;

  f2x_classify #(.SHORT_GAP(SHORT_GAP)) u_cls (
    .operand   (in_operand),
    .cls       (cls),
    .exp_short (exp_short)
  );

  f2x_resolve u_res (
    .operand      (in_operand),
    .cls          (cls),
    .ctrl         (in_ctrl),
    .stat         (in_status),
    .res          (res_d),
    .st           (st_d),
    .want_compute (want_compute),
    .was_denorm   (was_denorm)
  );

  assign dir_fire = in_valid && !want_compute;
  assign cmp_fire = in_valid && want_compute;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      cmp_req    <= 1'b0;
      cmp_denorm <= 1'b0;
      cmp_short  <= 1'b0;
      out_result <= '0;
      out_status <= '0;
    end else begin
      out_valid  <= dir_fire;
      cmp_req    <= cmp_fire;
      cmp_denorm <= cmp_fire && was_denorm;
      cmp_short  <= cmp_fire && exp_short;
      if (in_valid) begin
        out_result <= res_d;
        out_status <= st_d;
      end
    end
  end

  assign any_out = out_valid || cmp_req;

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && cmp_req)); // R9
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> any_out); // R9
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !any_out); // R9
  AST_TOP_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> (out_status[SW_TLO +: 3] == 3'b111)); // R1
  AST_EXC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    any_out |-> (out_status[SW_ES] == out_status[SW_B])); // R4
  AST_REQ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_req |-> (!out_status[SW_IE] && !out_status[SW_PE] && !out_status[SW_ES])); // R2
  AST_DENORM_DE: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_denorm |-> (cmp_req && out_status[SW_DE])); // R7
  AST_SHORT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_short |-> cmp_req); // R10
endmodule

// File: tb/tb_f2x_front.sv
module tb_f2x_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [79:0] in_operand = '0;
  logic [15:0] in_ctrl = '0;
  logic [15:0] in_status = '0;
  logic        out_valid, cmp_req, cmp_denorm, cmp_short;
  logic [79:0] out_result;
  logic [15:0] out_status;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  f2x_front dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_ctrl(in_ctrl), .in_status(in_status), .out_valid(out_valid),
    .out_result(out_result), .out_status(out_status), .cmp_req(cmp_req),
    .cmp_denorm(cmp_denorm), .cmp_short(cmp_short)
  );

  localparam logic [63:0] UNIT = 64'h8000_0000_0000_0000;
  localparam logic [15:0] ST0  = 16'h3800;   // TOP=7, nothing else
  localparam logic [15:0] EXC  = 16'h8080;   // ES | B

  function automatic logic [79:0] fp(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  task automatic chk(input string req, input string what, input logic [95:0] act,
                     input logic [95:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // apply one operand, sample registered outputs one cycle later
  task automatic apply(input logic [79:0] op, input logic [15:0] cw, input logic [15:0] sw);
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_ctrl = cw; in_status = sw;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_direct(input string req, input logic [79:0] res, input logic [15:0] st);
    chk(req, "out_valid", 96'(out_valid), 96'd1);
    chk(req, "cmp_req", 96'(cmp_req), 96'd0);
    chk(req, "result", 96'(out_result), 96'(res));
    chk(req, "status", 96'(out_status), 96'(st));
  endtask

  task automatic expect_compute(input string req, input logic [79:0] op, input logic [15:0] st,
                                input logic den, input logic shrt);
    chk(req, "out_valid", 96'(out_valid), 96'd0);
    chk(req, "cmp_req", 96'(cmp_req), 96'd1);
    chk(req, "forwarded", 96'(out_result), 96'(op));
    chk(req, "status", 96'(out_status), 96'(st));
    chk(req, "denorm", 96'(cmp_denorm), 96'(den));
    chk(req, "short", 96'(cmp_short), 96'(shrt));
  endtask

  task automatic t_reset();
    chk("R9", "reset out_valid", 96'(out_valid), 96'd0);
    chk("R9", "reset cmp_req", 96'(cmp_req), 96'd0);
  endtask

  task automatic t_status_seed();
    apply(fp(1'b0, 15'h0, 64'h0), 16'h007F, 16'hFFFF);
    expect_direct("R1", fp(1'b0, 15'h0, 64'h0), 16'h7D00);
    apply(fp(1'b1, 15'h0, 64'h0), 16'h007F, 16'h0100);
    expect_direct("R1", fp(1'b1, 15'h0, 64'h0), 16'h3900);
  endtask

  task automatic t_compute();
    logic [79:0] half;
    half = fp(1'b0, 15'h3FFE, UNIT);
    apply(half, 16'h0000, 16'h0000);
    expect_compute("R2", half, ST0, 1'b0, 1'b0);
    apply(fp(1'b1, 15'h3FFE, 64'hFFFF_FFFF_FFFF_FFFF), 16'h0000, 16'h4000);
    expect_compute("R2", fp(1'b1, 15'h3FFE, 64'hFFFF_FFFF_FFFF_FFFF), 16'h7800, 1'b0, 1'b0);
  endtask

  task automatic t_short_edge();
    apply(fp(1'b0, 15'h3FBA, UNIT), 16'h0000, 16'h0000);
    expect_compute("R10", fp(1'b0, 15'h3FBA, UNIT), ST0, 1'b0, 1'b1);
    apply(fp(1'b0, 15'h3FBB, UNIT), 16'h0000, 16'h0000);
    expect_compute("R10", fp(1'b0, 15'h3FBB, UNIT), ST0, 1'b0, 1'b0);
  endtask

  task automatic t_unit();
    apply(fp(1'b0, 15'h3FFF, UNIT), 16'h007F, 16'h0000);
    expect_direct("R3", fp(1'b0, 15'h3FFF, UNIT), ST0 | 16'h0020);
    apply(fp(1'b1, 15'h3FFF, UNIT), 16'h0040, 16'h0000);
    expect_direct("R3", fp(1'b1, 15'h3FFE, UNIT), ST0 | 16'h0020 | EXC);
  endtask

  task automatic t_large();
    apply(fp(1'b0, 15'h4000, 64'hC000_0000_0000_0000), 16'h007F, 16'h0000);
    expect_direct("R4", fp(1'b0, 15'h4000, 64'hC000_0000_0000_0000), ST0 | 16'h0020);
    apply(fp(1'b1, 15'h3FFF, 64'hC000_0000_0000_0000), 16'h0000, 16'h0000);
    expect_direct("R4", fp(1'b1, 15'h3FFF, 64'hC000_0000_0000_0000), ST0 | 16'h0020 | EXC);
  endtask

  task automatic t_passthru();
    apply(fp(1'b0, 15'h7FFF, 64'hC000_0000_0000_0001), 16'h0000, 16'h0000);
    expect_direct("R5", fp(1'b0, 15'h7FFF, 64'hC000_0000_0000_0001), ST0);
    apply(fp(1'b1, 15'h7FFF, 64'hC000_0000_0000_0000), 16'h0000, 16'h0000);
    expect_direct("R5", fp(1'b1, 15'h7FFF, 64'hC000_0000_0000_0000), ST0);
  endtask

  task automatic t_inf();
    apply(fp(1'b0, 15'h7FFF, UNIT), 16'h0000, 16'h0000);
    expect_direct("R6", fp(1'b0, 15'h7FFF, UNIT), ST0);
    apply(fp(1'b1, 15'h7FFF, UNIT), 16'h0000, 16'h0000);
    expect_direct("R6", fp(1'b1, 15'h3FFF, UNIT), ST0);
  endtask

  task automatic t_denorm();
    apply(fp(1'b0, 15'h0, 64'h1), 16'h0002, 16'h0000);
    expect_compute("R7", fp(1'b0, 15'h0, 64'h1), ST0 | 16'h0002, 1'b1, 1'b1);
    apply(fp(1'b0, 15'h0, 64'h1), 16'h0000, 16'h0000);
    expect_direct("R7", fp(1'b0, 15'h0, 64'h1), ST0 | 16'h0002 | EXC);
    apply(fp(1'b1, 15'h0, 64'h8000_0000_0000_0001), 16'h0002, 16'h0000);
    expect_compute("R7", fp(1'b1, 15'h0, 64'h8000_0000_0000_0001), ST0 | 16'h0002, 1'b1, 1'b1);
  endtask

  task automatic t_invalid();
    logic [79:0] indef;
    indef = fp(1'b1, 15'h7FFF, 64'hC000_0000_0000_0000);
    apply(fp(1'b0, 15'h4000, 64'h4000_0000_0000_0000), 16'h0001, 16'h0000);
    expect_direct("R8", indef, ST0 | 16'h0001);
    apply(fp(1'b0, 15'h4000, 64'h4000_0000_0000_0000), 16'h0000, 16'h0000);
    expect_direct("R8", fp(1'b0, 15'h4000, 64'h4000_0000_0000_0000), ST0 | 16'h0001 | EXC);
    apply(fp(1'b0, 15'h7FFF, 64'h4000_0000_0000_0000), 16'h0001, 16'h0000);
    expect_direct("R8", indef, ST0 | 16'h0001);
    apply(fp(1'b0, 15'h7FFF, 64'hA000_0000_0000_0000), 16'h0001, 16'h0000);
    expect_direct("R8", fp(1'b0, 15'h7FFF, 64'hE000_0000_0000_0000), ST0 | 16'h0001);
    apply(fp(1'b0, 15'h7FFF, 64'hA000_0000_0000_0000), 16'h0000, 16'h0000);
    expect_direct("R8", fp(1'b0, 15'h7FFF, 64'hA000_0000_0000_0000), ST0 | 16'h0001 | EXC);
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk("R9", "idle out_valid", 96'(out_valid), 96'd0);
    chk("R9", "idle cmp_req", 96'(cmp_req), 96'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status_seed();
    t_compute();
    t_short_edge();
    t_unit();
    t_large();
    t_passthru();
    t_inf();
    t_denorm();
    t_invalid();
    t_idle();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      summary();
    end
  end
endmodule